// File: doc/BRIEF.md
# Remote Terminal Buffer Memory Interface

This block connects the protocol engine of a MIL-STD-1553 remote terminal to an external single-port buffer RAM of 2048 sixteen-bit words. The engine hands over one word transfer at a time. Each transfer carries a direction (receive or transmit), a subaddress, a word index and a flag that marks it as an end-of-message status word. The block turns these into a RAM address with a fixed buffer map. It then asks an external arbiter for the memory bus with an active-low request and waits for the grant. While the grant lasts, it drives enables for external tristate drivers on the control and address lines and on the data lines. It then performs one read or write strobe, stretched by a wait input when the memory is slow.

The RAM is split into sixty-four 32-word buffers. Receive data for subaddress 1 to 30 goes to the lower half at subaddress×32 plus index. Transmit data for subaddress 1 to 30 comes from the upper half at 0x400 plus subaddress×32 plus index. The lower-half slots of subaddresses 0 and 31 hold status words: receive status at 0x000 plus subaddress and transmit status at 0x3E0 plus subaddress. When the loopback input is high, a transmit of subaddress 30 reads back the receive buffer of subaddress 30.

The controller is one state machine. Its states are IDLE, REQ, ADDR, STRB, HOLD, LATCH, REL and SKIP. The transitions are as follows. IDLE goes to REQ when a mapped transfer is offered, or to SKIP for a word transfer to subaddress 0 or 31. REQ stays put until the grant is sampled high, then goes to ADDR. ADDR always goes to STRB, and STRB always goes to HOLD. HOLD stays put while the wait input is high and goes to LATCH once it is low. LATCH goes to REL, REL goes to IDLE, and SKIP goes to IDLE.

Top module: `rt_bufmem_if`

## Requirements
- R1: After reset the request, read strobe and write strobe outputs are high (inactive), both driver enables and the done pulse are low, and the block is ready.
- R2: A receive word transfer to subaddress 1..30 writes its data at address {0, subaddress[4:0], index[4:0]}. The block issues a write strobe only to addresses below 0x400.
- R3: A transmit word transfer to subaddress 1..30 with loopback low reads address {1, subaddress[4:0], index[4:0]}. The read strobe is used only in the upper half or in the subaddress-30 receive buffer.
- R4: A status transfer is a write to 0x000 + subaddress for the receive direction and to 0x3E0 + subaddress for the transmit direction.
- R5: Loopback is sampled when a transfer is accepted. A transmit of subaddress 30 with loopback high reads 0x3C0 + index, and with loopback low it reads 0x7C0 + index.
- R6: A word transfer (status flag low) to subaddress 0 or 31 makes no bus request. Its done pulse comes in the cycle after acceptance.
- R7: The control enable is high only while the request is asserted, from the cycle after the grant is sampled until LATCH. The data enable is high only together with the control enable, and only on writes.
- R8: The request goes low in the cycle after a mapped transfer is accepted and stays low until the grant is sampled high.
- R9: Done is pulsed exactly 4 + W cycles after the edge that samples the grant, where W is the number of HOLD cycles with the wait input high. The request is released in the cycle that follows done, which makes each access 5 + W cycles from the grant.
- R10: The write strobe is a single-cycle low pulse in STRB. The read strobe stays low through STRB and HOLD. Address, data and strobes are stable while wait is high. Read data is captured at the edge that ends the first HOLD cycle with wait low, and it is presented with done.
- R11: The ready output is high only in IDLE. A valid offered while not ready is ignored and causes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_valid | input | 1 | Engine offers a transfer |
| xfer_ready | output | 1 | Block can accept a transfer (IDLE) |
| xfer_tx | input | 1 | 1 = transmit direction, 0 = receive |
| xfer_stat | input | 1 | 1 = end-of-message status word write |
| xfer_sa | input | 5 | Subaddress |
| xfer_idx | input | 5 | Word index within the buffer |
| xfer_wdata | input | DATA_W | Word to write |
| loop_sa30 | input | 1 | Loopback of subaddress 30 |
| xfer_done | output | 1 | One-cycle completion pulse |
| xfer_rdata | output | DATA_W | Word read from RAM |
| mem_req_n | output | 1 | Active-low bus request to the arbiter |
| mem_gnt | input | 1 | Bus grant |
| mem_wait | input | 1 | Memory inserts a wait cycle |
| mem_addr | output | 11 | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low read strobe |
| ctl_en | output | 1 | Enable for control and address drivers |
| dat_en | output | 1 | Enable for data drivers |

## Verification
The assertions assume that the engine raises valid only when ready is high, and that the arbiter holds the grant until the request is released. They also assume that wait only matters in HOLD, and that the engine never offers a word transfer to a status slot it wishes to keep. The bench models the arbiter and the memory from its own counters. It raises the grant a programmed number of cycles after the request falls, and raises wait only for the first HOLD cycles of a phase. The engine side offers a new transfer only after the previous one has finished. The one exception is a deliberate offer made while the block is busy, to show that it is ignored.

// File: rtl/rt_bufmem_pkg.sv
package rt_bufmem_pkg;
    localparam int SA_W         = 5;
    localparam int IDX_W        = 5;
    localparam int ADDR_W       = 1 + SA_W + IDX_W;
    localparam int RX_STAT_BASE = 'h000;
    localparam int TX_STAT_BASE = 'h3E0;
    localparam int LOOP_SA      = 30;

    typedef enum logic [2:0] {
        ST_IDLE, ST_REQ, ST_ADDR, ST_STRB, ST_HOLD, ST_LATCH, ST_REL, ST_SKIP
    } bstate_t;
endpackage

// File: rtl/rt_bufmem_map.sv
module rt_bufmem_map
    import rt_bufmem_pkg::*;
(
    input  logic              is_tx,
    input  logic              is_stat,
    input  logic              loop_en,
    input  logic [SA_W-1:0]   sa,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr,
    output logic              is_write,
    output logic              skip
);
    localparam logic [SA_W-1:0] SA_LAST = '1;
    localparam logic [SA_W-1:0] SA_LOOP = SA_W'(LOOP_SA);

    always_comb begin
        addr     = '0;
        is_write = !is_tx;
        skip     = 1'b0;
        if (is_stat) begin
            is_write = 1'b1;
            addr     = (is_tx ? ADDR_W'(TX_STAT_BASE) : ADDR_W'(RX_STAT_BASE)) + ADDR_W'(sa);
        end else if (sa == '0 || sa == SA_LAST) begin
            skip = 1'b1;
        end else if (!is_tx || (loop_en && sa == SA_LOOP)) begin
            addr = {1'b0, sa, idx};
        end else begin
            addr = {1'b1, sa, idx};
        end
    end
endmodule

// File: rtl/rt_bufmem_fsm.sv
module rt_bufmem_fsm
    import rt_bufmem_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_valid,
    input  logic [ADDR_W-1:0] map_addr,
    input  logic              map_write,
    input  logic              map_skip,
    input  logic [DATA_W-1:0] xfer_wdata,
    output logic              xfer_ready,
    output logic              xfer_done,
    output logic [DATA_W-1:0] xfer_rdata,
    output logic              mem_req_n,
    input  logic              mem_gnt,
    input  logic              mem_wait,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic              ctl_en,
    output logic              dat_en
);
    bstate_t           state, state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              wr_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (xfer_valid) state_nx = map_skip ? ST_SKIP : ST_REQ;
            ST_REQ:   if (mem_gnt) state_nx = ST_ADDR;
            ST_ADDR:  state_nx = ST_STRB;
            ST_STRB:  state_nx = ST_HOLD;
            ST_HOLD:  if (!mem_wait) state_nx = ST_LATCH;
            ST_LATCH: state_nx = ST_REL;
            ST_REL:   state_nx = ST_IDLE;
            ST_SKIP:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (state == ST_IDLE && xfer_valid) begin
                addr_q  <= map_addr;
                wdata_q <= xfer_wdata;
                wr_q    <= map_write;
            end
            if (state == ST_HOLD && !mem_wait && !wr_q) rdata_q <= mem_rdata;
        end
    end

    always_comb begin
        xfer_ready = (state == ST_IDLE);
        xfer_done  = (state == ST_LATCH) || (state == ST_SKIP);
        ctl_en     = state inside {ST_ADDR, ST_STRB, ST_HOLD, ST_LATCH};
        mem_req_n  = !(ctl_en || state == ST_REQ);
        dat_en     = ctl_en && wr_q;
        mem_wr_n   = !(state == ST_STRB && wr_q);
        mem_rd_n   = !((state == ST_STRB || state == ST_HOLD) && !wr_q);
        mem_addr   = addr_q;
        mem_wdata  = wdata_q;
        xfer_rdata = rdata_q;
    end

    p_ctl_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_en |-> !mem_req_n);
    p_dat_needs_ctl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dat_en |-> (ctl_en && mem_rd_n));
    p_wr_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |=> mem_wr_n);
    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && mem_wait) |=>
            ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_rd_n)));
    p_req_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> mem_req_n);
    p_write_low_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> !mem_addr[ADDR_W-1]);
    p_read_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> (mem_addr[ADDR_W-1] || mem_addr[ADDR_W-2 -: SA_W] == SA_W'(LOOP_SA)));
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_ready |=> $stable(mem_addr));
    p_strobes_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_wr_n && !mem_rd_n));
endmodule

// File: rtl/rt_bufmem_if.sv
module rt_bufmem_if
    import rt_bufmem_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_valid,
    output logic              xfer_ready,
    input  logic              xfer_tx,
    input  logic              xfer_stat,
    input  logic [4:0]        xfer_sa,
    input  logic [4:0]        xfer_idx,
    input  logic [DATA_W-1:0] xfer_wdata,
    input  logic              loop_sa30,
    output logic              xfer_done,
    output logic [DATA_W-1:0] xfer_rdata,
    output logic              mem_req_n,
    input  logic              mem_gnt,
    input  logic              mem_wait,
    output logic [10:0]       mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic              ctl_en,
    output logic              dat_en
);
    logic [ADDR_W-1:0] map_addr;
    logic              map_write, map_skip;

    rt_bufmem_map u_map (
        .is_tx    (xfer_tx),
        .is_stat  (xfer_stat),
        .loop_en  (loop_sa30),
        .sa       (xfer_sa),
        .idx      (xfer_idx),
        .addr     (map_addr),
        .is_write (map_write),
        .skip     (map_skip)
    );

    rt_bufmem_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_valid (xfer_valid),
        .map_addr   (map_addr),
        .map_write  (map_write),
        .map_skip   (map_skip),
        .xfer_wdata (xfer_wdata),
        .xfer_ready (xfer_ready),
        .xfer_done  (xfer_done),
        .xfer_rdata (xfer_rdata),
        .mem_req_n  (mem_req_n),
        .mem_gnt    (mem_gnt),
        .mem_wait   (mem_wait),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_wr_n   (mem_wr_n),
        .mem_rd_n   (mem_rd_n),
        .ctl_en     (ctl_en),
        .dat_en     (dat_en)
    );
endmodule

// File: tb/sim_rt_bufmem_if.sv
module sim_rt_bufmem_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_valid = 1'b0, xfer_tx = 1'b0, xfer_stat = 1'b0, loop_sa30 = 1'b0;
    logic [4:0]  xfer_sa = '0, xfer_idx = '0;
    logic [15:0] xfer_wdata = '0;
    logic        xfer_ready, xfer_done, mem_req_n, mem_wr_n, mem_rd_n, ctl_en, dat_en;
    logic [15:0] xfer_rdata, mem_wdata, mem_rdata;
    logic [10:0] mem_addr;
    logic        mem_gnt = 1'b0, mem_wait = 1'b0;

    always #10 clk = ~clk;

    rt_bufmem_if u0 (.*);

    logic [15:0] mem [0:2047];
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (!mem_wr_n) mem[mem_addr] <= mem_wdata;

    int    errors = 0, checks = 0;
    int    gdelay = 0, nwait = 0, gcnt = 0, c = 0;
    bit    in_phase = 0, expect_active = 0, exp_wr = 0;
    int    exp_addr = 0;
    int    exp_wdata = 0;
    string cur_tag = "R1";

    function automatic logic [15:0] pattern(input int a);
        return 16'(a) ^ 16'hA5C3;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // behavioural arbiter, wait source and cycle-by-cycle reference
    always @(negedge clk) begin
        if (rst_n) begin
            if (in_phase) c = c + 1;
            if (in_phase) begin
                if (c <= 4 + nwait) begin
                    check(ctl_en == 1 && mem_req_n == 0, "R7", "ctl_en/req in grant phase", {ctl_en, mem_req_n}, 2'b10);
                    check(mem_addr == 11'(exp_addr), cur_tag, "mem_addr", mem_addr, exp_addr);
                    check(dat_en == exp_wr, "R7", "dat_en", dat_en, exp_wr);
                    if (exp_wr) check(mem_wdata == 16'(exp_wdata), cur_tag, "mem_wdata", mem_wdata, exp_wdata);
                    check(mem_wr_n == !(exp_wr && c == 2), "R10", "wr strobe", mem_wr_n, !(exp_wr && c == 2));
                    check(mem_rd_n == !(!exp_wr && c >= 2 && c <= 3 + nwait), "R10", "rd strobe",
                          mem_rd_n, !(!exp_wr && c >= 2 && c <= 3 + nwait));
                    check(xfer_done == (c == 4 + nwait), "R9", "done timing", xfer_done, c == 4 + nwait);
                    if (c == 4 + nwait && !exp_wr)
                        check(xfer_rdata == mem[exp_addr], "R10", "read data", xfer_rdata, mem[exp_addr]);
                end else begin
                    check(mem_req_n == 1 && ctl_en == 0 && xfer_done == 0, "R9", "release cycle",
                          {mem_req_n, ctl_en, xfer_done}, 3'b100);
                    in_phase = 0;
                    expect_active = 0;
                end
            end else begin
                check(ctl_en == 0 && dat_en == 0 && mem_wr_n == 1 && mem_rd_n == 1, "R7",
                      "idle enables/strobes", {ctl_en, dat_en, mem_wr_n, mem_rd_n}, 4'b0011);
            end
            if (!mem_req_n) begin
                if (gcnt >= gdelay) mem_gnt = 1'b1;
                else gcnt++;
            end else begin
                mem_gnt = 1'b0;
                gcnt = 0;
            end
            if (!in_phase && mem_gnt && !mem_req_n) begin
                in_phase = 1;
                c = 0;
            end
            mem_wait = in_phase && c >= 3 && c < 3 + nwait;
        end
    end

    task automatic do_xfer(input bit tx, input bit stat, input int sa, input int idx,
                           input int wd, input bit loop, input int gd, input int nw,
                           input int ea, input bit ewr, input bit eskip, input bit poke,
                           input string tag);
        @(negedge clk);
        check(xfer_ready == 1, "R11", "ready before offer", xfer_ready, 1);
        xfer_tx = tx; xfer_stat = stat; xfer_sa = 5'(sa); xfer_idx = 5'(idx);
        xfer_wdata = 16'(wd); loop_sa30 = loop; xfer_valid = 1'b1;
        gdelay = gd; nwait = nw; exp_addr = ea; exp_wr = ewr; exp_wdata = wd;
        cur_tag = tag; expect_active = !eskip;
        @(posedge clk);
        @(negedge clk);
        xfer_valid = 1'b0;
        loop_sa30 = !loop;
        if (eskip) begin
            check(xfer_done == 1 && mem_req_n == 1, "R6", "skip done, no request", {xfer_done, mem_req_n}, 2'b11);
        end else begin
            check(mem_req_n == 0 && xfer_done == 0, "R8", "request after accept", {mem_req_n, xfer_done}, 2'b00);
            if (poke) begin
                check(xfer_ready == 0, "R11", "not ready while busy", xfer_ready, 0);
                xfer_valid = 1'b1; xfer_tx = 1'b0; xfer_stat = 1'b0;
                xfer_sa = 5'd5; xfer_idx = 5'd3; xfer_wdata = 16'hDEAD;
            end
            for (int k = 0; k < 200 && expect_active; k++) @(negedge clk);
            xfer_valid = 1'b0;
            if (ewr) check(mem[ea] == 16'(wd), tag, "memory word written", mem[ea], wd);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int a = 0; a < 2048; a++) mem[a] = pattern(a);
        repeat (3) @(negedge clk);
        check(mem_req_n == 1 && mem_wr_n == 1 && mem_rd_n == 1, "R1", "reset strobes/request",
              {mem_req_n, mem_wr_n, mem_rd_n}, 3'b111);
        check(ctl_en == 0 && dat_en == 0 && xfer_done == 0 && xfer_ready == 1, "R1", "reset enables",
              {ctl_en, dat_en, xfer_done, xfer_ready}, 4'b0001);
        rst_n = 1'b1;
        // receive words
        do_xfer(0, 0, 1, 0, 'h1234, 0, 0, 0, 'h020, 1, 0, 0, "R2");
        do_xfer(0, 0, 30, 31, 'hBEEF, 0, 2, 2, 'h3DF, 1, 0, 0, "R2");
        // transmit words
        do_xfer(1, 0, 1, 5, 0, 0, 1, 0, 'h425, 0, 0, 0, "R3");
        do_xfer(1, 0, 17, 9, 0, 0, 0, 3, 'h629, 0, 0, 0, "R3");
        // status words
        do_xfer(0, 1, 4, 0, 'h0A04, 0, 0, 1, 'h004, 1, 0, 0, "R4");
        do_xfer(1, 1, 29, 0, 'h0B1D, 0, 1, 0, 'h3FD, 1, 0, 0, "R4");
        do_xfer(1, 1, 0, 7, 'h0C00, 0, 0, 0, 'h3E0, 1, 0, 0, "R4");
        // loopback of subaddress 30
        do_xfer(1, 0, 30, 31, 0, 1, 0, 1, 'h3DF, 0, 0, 0, "R5");
        do_xfer(1, 0, 30, 31, 0, 0, 0, 0, 'h7DF, 0, 0, 0, "R5");
        // unmapped word slots
        do_xfer(1, 0, 0, 2, 0, 0, 0, 0, 0, 0, 1, 0, "R6");
        do_xfer(0, 0, 31, 2, 'h7777, 0, 0, 0, 0, 1, 1, 0, "R6");
        check(mem[31*32+2] == pattern(31*32+2), "R6", "sa31 slot untouched", mem[31*32+2], pattern(31*32+2));
        // offer while busy
        do_xfer(1, 0, 9, 1, 0, 0, 3, 2, 'h521, 0, 0, 1, "R11");
        repeat (3) begin
            check(mem_req_n == 1 && xfer_ready == 1, "R11", "no access from busy offer",
                  {mem_req_n, xfer_ready}, 2'b11);
            @(negedge clk);
        end
        check(mem[5*32+3] == pattern(5*32+3), "R11", "busy offer not written", mem[5*32+3], pattern(5*32+3));
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule